// File: doc/BRIEF.md
# Simultaneous-Sampling Converter Sequencer

This block is the digital control core of a four-channel simultaneous-sampling converter, written as a synthesizable behavioural model. A convert-start strobe freezes a channel mask. The mask comes either from four hardware select pins or from a 4-bit channel register that the host writes. The block raises a busy flag while it steps through the enabled channels in ascending order. Each channel takes a fixed, configurable number of clocks. A stub produces each channel's result word.

Once conversion ends, the host reads the results one per read strobe over a 12-bit data bus. A flag marks the word of the lowest enabled channel. The bus is split into a data output, an output enable and a 4-bit write input, and the pad ring joins them into one tri-state bus. The convert, chip-select, read and write strobes are brought into the clock domain through two-flop synchronisers, and the block acts on edges of the synchronised copies.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A rising edge on `convst`, accepted while `run_n_stby` is high and `busy` is low, raises `busy` and latches the channel mask.
- R2: `busy` stays high for exactly n×CONV_CLKS clock cycles, where n is the number of set mask bits. An all-zero mask gives `busy` high for exactly one cycle.
- R3: With `sw_sel`=0 the mask is taken from `sel_pins`. With `sw_sel`=1 it is taken from the channel register. Only the value present at the accepted start is used, and later changes do not alter the run in progress.
- R4: A rising edge of `wr_n` while `cs_n` is low and `rd_n` is high loads `data_i[3:0]` into the channel register. A `wr_n` edge while `cs_n` is high leaves the register unchanged.
- R5: `data_oe` is high exactly while `cs_n` and `rd_n` are both low.
- R6: Mask bit k enables channel k (0..3), and channels convert in ascending order. The result word of channel k is {k in bits 11:10, 0 in bits 9:8, and in bits 7:0 the count of accepted starts since reset, where the first start is 1}.
- R7: Each completed read (`rd_n` rising while `cs_n` is low) moves the output to the next higher enabled channel. After the highest enabled channel it wraps to the lowest.
- R8: `first_o` is high while the output points at the lowest enabled channel of the latched mask.
- R9: A `convst` rising edge while `busy` is high is ignored. It neither lengthens `busy` nor increments the start count.
- R10: While `run_n_stby` is low, `convst` edges start no conversion.
- R11: An accepted start returns the output to the lowest enabled channel of the new mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| convst | input | 1 | Convert start; acts on its rising edge |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; acts on its rising edge |
| sel_pins | input | 4 | Hardware channel mask, bit k = channel k |
| sw_sel | input | 1 | 0: mask from pins, 1: mask from channel register |
| run_n_stby | input | 1 | High: normal operation, low: standby |
| data_i | input | 4 | Low nibble of the bus as driven by the host |
| data_o | output | 12 | Result word of the current output channel |
| data_oe | output | 1 | Drive enable for the data bus pads |
| busy | output | 1 | High while a conversion run is in progress |
| first_o | output | 1 | High when the output is at the first result |

## Verification
Conversions are run with masks of one, two, three and four channels and with the empty mask. The busy width, measured in cycles, separates a correct per-channel count from an off-by-one or a constant duration. Pin-sourced and register-sourced masks are set to disagree with each other, so selecting the wrong source changes both the busy width and the channel field of the words read back. Further cases change the pins mid-run, pulse start during a run and in standby, attempt a write with chip select high, and read past the last word. These expose a mask that is not latched, a start that should have been ignored and was not, and a pointer that fails to wrap or to return to the first channel on a new start.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int NCH   = 4;
    localparam int CH_W  = $clog2(NCH);
    localparam int RES_W = 12;
    localparam int RUN_W = 8;

    typedef logic [NCH-1:0]   mask_t;
    typedef logic [CH_W-1:0]  ch_t;
    typedef logic [RES_W-1:0] word_t;

    // lowest enabled channel, 0 when the mask is empty
    function automatic ch_t lowest_ch(input mask_t m);
        ch_t r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i]) r = ch_t'(i);
        end
        return r;
    endfunction

    // next enabled channel above p, wrapping; p itself when alone
    function automatic ch_t next_ch(input mask_t m, input ch_t p);
        ch_t r;
        ch_t idx;
        logic found;
        r = p;
        found = 1'b0;
        for (int i = 1; i < NCH; i++) begin
            idx = ch_t'(int'(p) + i);
            if (!found && m[idx]) begin
                r = idx;
                found = 1'b1;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= RST_VAL;
                else        pipe_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
                else        pipe_q <= {pipe_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/adc_conv_engine.sv
module adc_conv_engine
    import adc_seq_pkg::*;
#(
    parameter int CONV_CLKS = 4,
    localparam int CNT_W = $clog2(CONV_CLKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  mask_t            mask_i,
    output logic             accept_o,
    output logic             busy_o,
    output mask_t            seq_o,
    output word_t [NCH-1:0]  res_o
);
    typedef struct packed {
        logic             busy;
        mask_t            seq;
        mask_t            pend;
        logic [CNT_W-1:0] cnt;
        logic [RUN_W-1:0] run;
        word_t [NCH-1:0]  res;
    } eng_t;

    eng_t q, d;
    ch_t  cur_ch;

    assign accept_o = start_i && !q.busy;
    assign cur_ch   = lowest_ch(q.pend);

    always_comb begin
        d = q;
        if (accept_o) begin
            d.busy = 1'b1;
            d.seq  = mask_i;
            d.pend = mask_i;
            d.cnt  = '0;
            d.run  = q.run + 1'b1;
        end else if (q.busy) begin
            if (q.pend == '0) begin
                d.busy = 1'b0;
            end else if (q.cnt == CNT_W'(CONV_CLKS - 1)) begin
                d.res[cur_ch]  = {cur_ch, 2'b00, q.run};
                d.pend[cur_ch] = 1'b0;
                d.cnt          = '0;
                if ((q.pend & ~(mask_t'(1) << cur_ch)) == '0) d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign seq_o  = q.seq;
    assign res_o  = q.res;

    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> busy_o);
    assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $countones($past(q.pend)) <= 1);
    assert_seq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(seq_o));
    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> $stable(q.run));
endmodule

// File: rtl/adc_readout.sv
module adc_readout
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  mask_t            mask_i,
    input  mask_t            seq_i,
    input  logic             rd_done_i,
    input  word_t [NCH-1:0]  res_i,
    output word_t            word_o,
    output logic             first_o
);
    typedef struct packed {
        ch_t ptr;
    } rdo_t;

    rdo_t q, d;

    always_comb begin
        d = q;
        if (accept_i)       d.ptr = lowest_ch(mask_i);
        else if (rd_done_i) d.ptr = next_ch(seq_i, q.ptr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_o  = res_i[q.ptr];
    assign first_o = (q.ptr == lowest_ch(seq_i));

    assert_ptr_on_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_i != '0) |-> seq_i[q.ptr]);
    assert_reset_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i |=> first_o);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CONV_CLKS = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        convst,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [3:0]  sel_pins,
    input  logic        sw_sel,
    input  logic        run_n_stby,
    input  logic [3:0]  data_i,
    output logic [11:0] data_o,
    output logic        data_oe,
    output logic        busy,
    output logic        first_o
);
    localparam int NSTR = 4;    // convst, cs_n, rd_n, wr_n

    typedef struct packed {
        logic [NSTR-1:0] prev;
        mask_t           creg;
    } top_t;

    top_t q, d;
    logic [NSTR-1:0] s;
    logic cv_rise, wr_rise, rd_rise, cs_low, start, accept;
    mask_t sel_mask, seq;
    word_t [NCH-1:0] res;

    adc_sync #(.W(NSTR), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({convst, cs_n, rd_n, wr_n}), .q(s)
    );

    assign cv_rise  = s[3] && !q.prev[3];
    assign cs_low   = !s[2];
    assign rd_rise  = s[1] && !q.prev[1];
    assign wr_rise  = s[0] && !q.prev[0];
    assign start    = cv_rise && run_n_stby;
    assign sel_mask = sw_sel ? q.creg : sel_pins;

    always_comb begin
        d = q;
        d.prev = s;
        if (wr_rise && cs_low && s[1]) d.creg = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{prev: 4'b0111, creg: '0};
        else        q <= d;
    end

    adc_conv_engine #(.CONV_CLKS(CONV_CLKS)) u_eng (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mask_i(sel_mask),
        .accept_o(accept), .busy_o(busy), .seq_o(seq), .res_o(res)
    );

    adc_readout u_rdo (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .mask_i(sel_mask),
        .seq_i(seq), .rd_done_i(rd_rise && cs_low), .res_i(res),
        .word_o(data_o), .first_o(first_o)
    );

    assign data_oe = !cs_n && !rd_n;

    assert_creg_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise && cs_low && s[1]) |=> (q.creg == $past(data_i)));
    assert_creg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> $stable(q.creg));
    assert_standby_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_n_stby && !busy) |=> !busy);
    assert_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> !data_oe);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    localparam int CC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic convst = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [3:0] sel_pins = 4'b0000;
    logic sw_sel = 1'b0, run_n_stby = 1'b1;
    logic [3:0] data_i = 4'b0000;
    logic [11:0] data_o;
    logic data_oe, busy, first_o;

    int checks = 0, fails = 0, runs = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_seq_ctrl #(.CONV_CLKS(CC)) u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .convst(convst), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .sel_pins(sel_pins), .sw_sel(sw_sel),
        .run_n_stby(run_n_stby), .data_i(data_i), .data_o(data_o),
        .data_oe(data_oe), .busy(busy), .first_o(first_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int word(input int ch, input int run);
        return (ch << 10) | (run & 8'hff);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // start pulse; returns busy width in cycles; extra start during busy if asked
    task automatic convert(output int width, input bit restart);
        int wait_c;
        width = 0;
        wait_c = 0;
        @(negedge clk);
        convst = 1'b1;
        while (!busy && wait_c < 10) begin
            @(negedge clk);
            wait_c++;
        end
        while (busy) begin
            width++;
            if (width == 2) convst = 1'b0;
            if (restart && width == 5) convst = 1'b1;
            if (restart && width == 8) convst = 1'b0;
            @(negedge clk);
        end
        convst = 1'b0;
        idle(4);
    endtask

    task automatic write_reg(input logic [3:0] v, input bit sel);
        @(negedge clk);
        cs_n = !sel;
        data_i = v;
        idle(1);
        wr_n = 1'b0;
        idle(3);
        wr_n = 1'b1;
        idle(4);
        cs_n = 1'b1;
        idle(3);
    endtask

    task automatic read_word(output int w, output bit f);
        @(negedge clk);
        cs_n = 1'b0;
        rd_n = 1'b0;
        idle(1);
        chk(data_oe == 1'b1, "R5 oe during read", int'(data_oe), 1);
        idle(2);
        w = int'(data_o);
        f = first_o;
        rd_n = 1'b1;
        idle(4);
        cs_n = 1'b1;
        idle(3);
        chk(data_oe == 1'b0, "R5 oe after read", int'(data_oe), 0);
    endtask

    task automatic expect_read(input int ch, input int run, input bit f, input string tag);
        int w;
        bit fo;
        read_word(w, fo);
        chk(w == word(ch, run), {tag, " word"}, w, word(ch, run));
        chk(fo == f, {tag, " first"}, int'(fo), int'(f));
    endtask

    task automatic t_reset;
        chk(busy == 1'b0, "reset busy", int'(busy), 0);
        chk(data_oe == 1'b0, "R5 reset oe", int'(data_oe), 0);
    endtask

    task automatic t_pins_two;
        int wd;
        sw_sel = 1'b0;
        sel_pins = 4'b0101;
        convert(wd, 1'b0);
        runs++;
        chk(wd == 2 * CC, "R1 R2 R3 pins 0101 busy width", wd, 2 * CC);
        expect_read(0, runs, 1'b1, "R6 R8 ch0");
        expect_read(2, runs, 1'b0, "R6 R7 ch2");
        expect_read(0, runs, 1'b1, "R7 wrap ch0");
    endtask

    task automatic t_sw_reg;
        int wd;
        write_reg(4'b1110, 1'b1);
        sw_sel = 1'b1;
        sel_pins = 4'b0001;
        convert(wd, 1'b0);
        runs++;
        chk(wd == 3 * CC, "R3 R4 register mask width", wd, 3 * CC);
        expect_read(1, runs, 1'b1, "R4 ch1");
        expect_read(2, runs, 1'b0, "R7 ch2");
        expect_read(3, runs, 1'b0, "R7 ch3");
        expect_read(1, runs, 1'b1, "R7 wrap ch1");
    endtask

    task automatic t_write_no_cs;
        int wd;
        write_reg(4'b0001, 1'b0);
        convert(wd, 1'b0);
        runs++;
        chk(wd == 3 * CC, "R4 write with cs high ignored", wd, 3 * CC);
        expect_read(1, runs, 1'b1, "R4 register kept");
    endtask

    task automatic t_change_midrun;
        int wd;
        sw_sel = 1'b0;
        sel_pins = 4'b1000;
        fork
            convert(wd, 1'b0);
            begin
                idle(5);
                sel_pins = 4'b1111;
                sw_sel = 1'b1;
            end
        join
        runs++;
        chk(wd == CC, "R3 mid-run change ignored width", wd, CC);
        expect_read(3, runs, 1'b1, "R3 R6 ch3 only");
        sw_sel = 1'b0;
    endtask

    task automatic t_empty;
        int wd;
        sel_pins = 4'b0000;
        convert(wd, 1'b0);
        runs++;
        chk(wd == 1, "R2 empty mask one cycle", wd, 1);
    endtask

    task automatic t_busy_restart;
        int wd;
        sel_pins = 4'b1111;
        convert(wd, 1'b1);
        runs++;
        chk(wd == 4 * CC, "R9 start during busy ignored width", wd, 4 * CC);
        expect_read(0, runs, 1'b1, "R9 count not bumped ch0");
        expect_read(1, runs, 1'b0, "R6 ch1");
        convert(wd, 1'b0);
        runs++;
        chk(wd == 4 * CC, "R2 four channels", wd, 4 * CC);
        expect_read(0, runs, 1'b1, "R11 pointer back to first");
    endtask

    task automatic t_standby;
        int hi;
        hi = 0;
        run_n_stby = 1'b0;
        idle(2);
        convst = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (busy) hi++;
        end
        convst = 1'b0;
        idle(4);
        chk(hi == 0, "R10 no start in standby", hi, 0);
        run_n_stby = 1'b1;
        idle(2);
        expect_read(1, runs, 1'b0, "R10 readout untouched");
    endtask

    task automatic t_oe;
        @(negedge clk);
        cs_n = 1'b0;
        rd_n = 1'b1;
        #1;
        chk(data_oe == 1'b0, "R5 cs low rd high", int'(data_oe), 0);
        cs_n = 1'b1;
        rd_n = 1'b0;
        #1;
        chk(data_oe == 1'b0, "R5 cs high rd low", int'(data_oe), 0);
        rd_n = 1'b1;
        idle(4);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);
        t_reset();
        t_pins_two();
        t_sw_reg();
        t_write_no_cs();
        t_change_midrun();
        t_empty();
        t_busy_restart();
        t_standby();
        t_oe();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule